// File: doc/BRIEF.md
# Receive Header Validator with Delimiter Search Timer

This block sits after the despreader and descrambler of a direct-sequence receiver. It takes one decided bit per strobe. Once the front end reports initial code lock, the block hunts for the 16-bit start frame delimiter within a programmable window. After a match it collects the 48-bit physical header and checks its CRC-16.

While the frame is live, the block raises a ready flag towards the network processor. A good header also yields the demodulation mode for the payload, together with the length and service fields. A bad header, an unknown rate code or a window that runs out without a delimiter each produce a one-cycle order to return the receiver to acquisition. A CRC failure additionally sets a sticky status bit that only a status read clears.

Top module: `rxh_hdr_check`

## Requirements
- R1: After reset, `hdr_rdy`, `reacq`, `crc_err` and `mode_vld` are all low.
- R2: With `short_mode` low, after a `lock_pulse` the 16 bits 0xF3A0, sent least significant bit first, raise `hdr_rdy` in the cycle after the strobe of the final delimiter bit.
- R3: With `short_mode` high, the delimiter is the bit-time reverse of the long one: 0x05CF, sent least significant bit first. The long pattern is then not accepted.
- R4: No delimiter is recognised unless all 16 of its bits arrived after a `lock_pulse` seen while idle. Bits received before lock, or after a search has ended, never raise `hdr_rdy`.
- R5: `tmo_sel` values 1, 2 and 3 end the search after 64, 128 and 256 bit strobes counted from lock. The window closes on the strobe with that count, if that strobe completes no delimiter. Value 0 disables the timeout. On expiry `reacq` pulses and the block idles.
- R6: The header is, in arrival order, rate code (8 bits), service (8), length (16) and CRC (16). The first three fields arrive least significant bit first. The CRC is x^16+x^12+x^5+1, preset to all ones, taken over those 32 bits. Its ones complement follows, most significant bit first. If the check passes and the rate code is known, then after the final bit `mode_vld` goes high, `hdr_len` and `hdr_svc` carry the fields, and `hdr_rdy` stays high.
- R7: On a CRC mismatch, after the final header bit `crc_err` is set, `hdr_rdy` falls and `reacq` pulses.
- R8: `crc_err` stays set until a `stat_rd` pulse clears it. Dropping `rx_en` does not clear it. If a new error arrives in the same cycle as `stat_rd`, the error wins.
- R9: While `rx_en` is low, the block idles. From the next cycle `hdr_rdy` and `mode_vld` are low and no `reacq` pulse is produced.
- R10: The rate code maps to `demod_mode` as follows: 0x0A gives 0 (DBPSK), 0x14 gives 1 (DQPSK), 0x37 gives 2 (CCK, 5.5), 0x6E gives 3 (CCK, 11). Any other code with a good CRC drops `hdr_rdy` and pulses `reacq` without setting `crc_err`.
- R11: `reacq` lasts one cycle and is never high together with `hdr_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low forces idle |
| short_mode | input | 1 | Selects the short-preamble delimiter |
| tmo_sel | input | 2 | Delimiter search window code |
| lock_pulse | input | 1 | Initial code lock reported |
| bit_vld | input | 1 | Bit strobe |
| bit_in | input | 1 | Descrambled received bit |
| stat_rd | input | 1 | Status read pulse, clears `crc_err` |
| hdr_rdy | output | 1 | Frame ready flag |
| reacq | output | 1 | One-cycle order to return to acquisition |
| crc_err | output | 1 | Sticky header CRC error |
| mode_vld | output | 1 | Header accepted, mode and fields valid |
| demod_mode | output | 2 | Payload demodulation mode |
| hdr_len | output | 16 | Length field |
| hdr_svc | output | 8 | Service field |

## Verification
The checks take for granted that `lock_pulse`, `stat_rd` and `bit_vld` are single-cycle synchronous strobes, and that `rx_en` is held steady across each frame. The directed sequences drive every input on the falling clock edge, present each bit as a one-cycle strobe followed by an idle cycle, and drop `rx_en` for a cycle between scenarios. Search windows are sized so that no preamble prefix can form a false delimiter. Lock is always issued from the idle state.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  localparam int SIG_W = 8;
  localparam int SVC_W = 8;
  localparam int LEN_W = 16;
  localparam int CRC_W = 16;
  localparam int FLD_W = SIG_W + SVC_W + LEN_W;
  localparam int HDR_W = FLD_W + CRC_W;

  localparam logic [CRC_W-1:0] CRC_POLY  = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED  = 16'hFFFF;
  // remainder left after the complemented check word has been shifted in
  localparam logic [CRC_W-1:0] CRC_RESID = 16'h1D0F;

  localparam logic [SIG_W-1:0] RATE_1M  = 8'h0A;
  localparam logic [SIG_W-1:0] RATE_2M  = 8'h14;
  localparam logic [SIG_W-1:0] RATE_5M5 = 8'h37;
  localparam logic [SIG_W-1:0] RATE_11M = 8'h6E;

  typedef enum logic [1:0] {ST_IDLE, ST_SRCH, ST_HDR, ST_DONE} rx_st_e;
  typedef enum logic [1:0] {MD_DBPSK, MD_DQPSK, MD_CCK55, MD_CCK11} demod_e;

  // first received bit sits at the LSB of each field
  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [SVC_W-1:0] svc;
    logic [SIG_W-1:0] sig;
  } hdr_flds_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/rxh_rst_sync.sv
module rxh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rxh_sfd_search.sv
module rxh_sfd_search #(
  parameter logic [15:0] SFD_LONG = 16'hF3A0,
  parameter int          TMO_UNIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       short_mode,
  input  logic [1:0] tmo_sel,
  output logic       found,
  output logic       expired
);
  localparam int SFD_W = 16;
  localparam int CNT_W = $clog2(TMO_UNIT * 4) + 1;

  logic [SFD_W-1:0] sfd_short;
  logic [SFD_W-1:0] sfd_pat;
  logic [SFD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, limit;
  logic             take, filled;

  // short delimiter is the long one reversed in time
  for (genvar i = 0; i < SFD_W; i++) begin : g_rev
    assign sfd_short[i] = SFD_LONG[SFD_W-1-i];
  end

  assign sfd_pat = short_mode ? sfd_short : SFD_LONG;

  always_comb begin
    case (tmo_sel)
      2'd1:    limit = CNT_W'(TMO_UNIT);
      2'd2:    limit = CNT_W'(2 * TMO_UNIT);
      2'd3:    limit = CNT_W'(4 * TMO_UNIT);
      default: limit = '0;
    endcase
  end

  assign take    = run && bit_vld;
  assign sh_d    = {bit_in, sh_q[SFD_W-1:1]};
  assign cnt_inc = cnt_q + 1'b1;
  assign filled  = cnt_q >= CNT_W'(SFD_W - 1);
  assign found   = take && filled && (sh_d == sfd_pat);
  assign expired = take && !found && (limit != '0) && (cnt_inc == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                         cnt_d = '0;
    else if (take && cnt_q != '1)    cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (clr)       sh_q <= '0;
      else if (take) sh_q <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rxh_hdr_collect.sv
module rxh_hdr_collect
  import rxh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      run,
  input  logic      bit_vld,
  input  logic      bit_in,
  output logic      last,
  output logic      crc_ok,
  output hdr_flds_t flds
);
  localparam int IDX_W = $clog2(HDR_W);

  logic [FLD_W-1:0] fld_q;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic [IDX_W-1:0] idx_q;
  logic             take, fld_en;

  assign take   = run && bit_vld;
  assign fld_en = take && (idx_q < IDX_W'(FLD_W));
  assign crc_d  = crc_step(crc_q, bit_in);
  assign last   = take && (idx_q == IDX_W'(HDR_W - 1));
  assign crc_ok = (crc_d == CRC_RESID);
  assign flds   = hdr_flds_t'(fld_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
      crc_q <= CRC_SEED;
      idx_q <= '0;
    end else if (clr) begin
      fld_q <= '0;
      crc_q <= CRC_SEED;
      idx_q <= '0;
    end else begin
      if (fld_en) fld_q <= {bit_in, fld_q[FLD_W-1:1]};
      if (take) begin
        crc_q <= crc_d;
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxh_sig_decode.sv
module rxh_sig_decode
  import rxh_pkg::*;
(
  input  logic [SIG_W-1:0] sig,
  output demod_e           mode,
  output logic             known
);
  always_comb begin
    known = 1'b1;
    mode  = MD_DBPSK;
    case (sig)
      RATE_1M:  mode = MD_DBPSK;
      RATE_2M:  mode = MD_DQPSK;
      RATE_5M5: mode = MD_CCK55;
      RATE_11M: mode = MD_CCK11;
      default:  known = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxh_hdr_check.sv
module rxh_hdr_check
  import rxh_pkg::*;
#(
  parameter logic [15:0] SFD_LONG = 16'hF3A0,
  parameter int          TMO_UNIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        short_mode,
  input  logic [1:0]  tmo_sel,
  input  logic        lock_pulse,
  input  logic        bit_vld,
  input  logic        bit_in,
  input  logic        stat_rd,
  output logic        hdr_rdy,
  output logic        reacq,
  output logic        crc_err,
  output logic        mode_vld,
  output logic [1:0]  demod_mode,
  output logic [15:0] hdr_len,
  output logic [7:0]  hdr_svc
);
  logic       rst_sn;
  rx_st_e     st_q, st_d;
  logic       rdy_q, rdy_d, reacq_q, reacq_d, err_q, err_d, mvld_q, mvld_d;
  logic       err_set, srch_clr, hdr_clr, cap_en;
  logic       sfd_found, sfd_expired, hdr_last, hdr_crc_ok, sig_known;
  demod_e     sig_mode, mode_q;
  hdr_flds_t  flds;
  logic [LEN_W-1:0] len_q;
  logic [SVC_W-1:0] svc_q;

  rxh_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rxh_sfd_search #(.SFD_LONG(SFD_LONG), .TMO_UNIT(TMO_UNIT)) u_sfd (
    .clk        (clk),
    .rst_n      (rst_sn),
    .clr        (srch_clr),
    .run        (st_q == ST_SRCH),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .short_mode (short_mode),
    .tmo_sel    (tmo_sel),
    .found      (sfd_found),
    .expired    (sfd_expired)
  );

  rxh_hdr_collect u_hdr (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr     (hdr_clr),
    .run     (st_q == ST_HDR),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .last    (hdr_last),
    .crc_ok  (hdr_crc_ok),
    .flds    (flds)
  );

  rxh_sig_decode u_dec (
    .sig   (flds.sig),
    .mode  (sig_mode),
    .known (sig_known)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    rdy_d    = rdy_q;
    mvld_d   = mvld_q;
    reacq_d  = 1'b0;
    err_set  = 1'b0;
    srch_clr = 1'b0;
    hdr_clr  = 1'b0;
    cap_en   = 1'b0;
    if (!rx_en) begin
      st_d     = ST_IDLE;
      rdy_d    = 1'b0;
      mvld_d   = 1'b0;
      srch_clr = 1'b1;
      hdr_clr  = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          srch_clr = 1'b1;
          hdr_clr  = 1'b1;
          rdy_d    = 1'b0;
          mvld_d   = 1'b0;
          if (lock_pulse) st_d = ST_SRCH;
        end
        ST_SRCH: begin
          hdr_clr = 1'b1;
          if (sfd_found) begin
            st_d  = ST_HDR;
            rdy_d = 1'b1;
          end else if (sfd_expired) begin
            st_d    = ST_IDLE;
            reacq_d = 1'b1;
          end
        end
        ST_HDR: begin
          if (hdr_last) begin
            if (!hdr_crc_ok) begin
              err_set = 1'b1;
              rdy_d   = 1'b0;
              reacq_d = 1'b1;
              st_d    = ST_IDLE;
            end else if (!sig_known) begin
              rdy_d   = 1'b0;
              reacq_d = 1'b1;
              st_d    = ST_IDLE;
            end else begin
              cap_en = 1'b1;
              mvld_d = 1'b1;
              st_d   = ST_DONE;
            end
          end
        end
        default: ;
      endcase
    end
    err_d = err_q;
    if (err_set)      err_d = 1'b1;
    else if (stat_rd) err_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q    <= ST_IDLE;
      rdy_q   <= 1'b0;
      reacq_q <= 1'b0;
      err_q   <= 1'b0;
      mvld_q  <= 1'b0;
      mode_q  <= MD_DBPSK;
      len_q   <= '0;
      svc_q   <= '0;
    end else begin
      st_q    <= st_d;
      rdy_q   <= rdy_d;
      reacq_q <= reacq_d;
      err_q   <= err_d;
      mvld_q  <= mvld_d;
      if (cap_en) begin
        mode_q <= sig_mode;
        len_q  <= flds.len;
        svc_q  <= flds.svc;
      end
    end
  end

  assign hdr_rdy    = rdy_q;
  assign reacq      = reacq_q;
  assign crc_err    = err_q;
  assign mode_vld   = mvld_q;
  assign demod_mode = mode_q;
  assign hdr_len    = len_q;
  assign hdr_svc    = svc_q;
endmodule

// File: rtl/rxh_checker.sv
module rxh_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic stat_rd,
  input logic bit_vld,
  input logic hdr_rdy,
  input logic reacq,
  input logic crc_err,
  input logic mode_vld
);
  a_r11_reacq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reacq |=> !reacq);

  a_r11_reacq_not_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    !(reacq && hdr_rdy));

  a_r9_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!hdr_rdy && !reacq && !mode_vld));

  a_r8_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crc_err) |-> $past(stat_rd));

  a_r7_err_drops_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> (reacq && !hdr_rdy));

  a_r2_rdy_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_rdy) |-> $past(bit_vld && rx_en));

  a_r5_reacq_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reacq) |-> $past(bit_vld && rx_en));

  a_r6_mode_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    mode_vld |-> hdr_rdy);
endmodule

bind rxh_hdr_check rxh_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_en    (rx_en),
  .stat_rd  (stat_rd),
  .bit_vld  (bit_vld),
  .hdr_rdy  (hdr_rdy),
  .reacq    (reacq),
  .crc_err  (crc_err),
  .mode_vld (mode_vld)
);

// File: tb/rxh_hdr_check_test.sv
module rxh_hdr_check_test;
  logic        clk = 1'b0;
  logic        rst_n, rx_en, short_mode, lock_pulse, bit_vld, bit_in, stat_rd;
  logic [1:0]  tmo_sel;
  logic        hdr_rdy, reacq, crc_err, mode_vld;
  logic [1:0]  demod_mode;
  logic [15:0] hdr_len;
  logic [7:0]  hdr_svc;
  int          checks = 0;
  int          errs = 0;
  bit          done = 1'b0;

  localparam logic [15:0] LONG_SFD  = 16'hF3A0;
  localparam logic [15:0] SHORT_SFD = 16'h05CF;

  always #10 clk = ~clk;

  rxh_hdr_check uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .short_mode(short_mode),
    .tmo_sel(tmo_sel), .lock_pulse(lock_pulse), .bit_vld(bit_vld),
    .bit_in(bit_in), .stat_rd(stat_rd), .hdr_rdy(hdr_rdy), .reacq(reacq),
    .crc_err(crc_err), .mode_vld(mode_vld), .demod_mode(demod_mode),
    .hdr_len(hdr_len), .hdr_svc(hdr_svc)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic rd);
    @(negedge clk);
    bit_vld = 1'b1; bit_in = b; stat_rd = rd;
    @(negedge clk);
    bit_vld = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic send_lock();
    @(negedge clk); lock_pulse = 1'b1;
    @(negedge clk); lock_pulse = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] p);
    for (int i = 0; i < 16; i++) send_bit(p[i], 1'b0);
  endtask

  task automatic send_fill(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b, 1'b0);
  endtask

  task automatic send_hdr(input logic [7:0] sig, input logic [7:0] svc,
                          input logic [15:0] len, input logic flip, input logic rd_last);
    logic [31:0] f;
    logic [15:0] c;
    logic        fb;
    f = {len, svc, sig};
    c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      fb = c[15] ^ f[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      send_bit(f[i], 1'b0);
    end
    c = ~c ^ {15'd0, flip};
    for (int j = 15; j >= 0; j--) send_bit(c[j], (j == 0) && rd_last);
  endtask

  task automatic restart();
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 hdr_rdy", hdr_rdy, 0);
    chk("R1 reacq", reacq, 0);
    chk("R1 crc_err", crc_err, 0);
    chk("R1 mode_vld", mode_vld, 0);
  endtask

  task automatic t_long_pkt();
    restart(); short_mode = 1'b0; tmo_sel = 2'd0;
    send_lock();
    send_fill(1'b1, 20);
    chk("R2 before delimiter", hdr_rdy, 0);
    send_word(LONG_SFD);
    chk("R2 rdy after long delimiter", hdr_rdy, 1);
    send_hdr(8'h6E, 8'hA5, 16'h1234, 1'b0, 1'b0);
    chk("R6 mode_vld", mode_vld, 1);
    chk("R6 rdy held", hdr_rdy, 1);
    chk("R10 mode 11M", demod_mode, 3);
    chk("R6 length", hdr_len, 16'h1234);
    chk("R6 service", hdr_svc, 8'hA5);
    chk("R11 no reacq", reacq, 0);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R9 rdy low", hdr_rdy, 0);
    chk("R9 mode_vld low", mode_vld, 0);
    chk("R9 no reacq", reacq, 0);
    rx_en = 1'b1;
  endtask

  task automatic t_short_pkt();
    restart(); short_mode = 1'b1; tmo_sel = 2'd0;
    send_lock();
    send_fill(1'b0, 10);
    send_word(LONG_SFD);
    chk("R3 long pattern refused", hdr_rdy, 0);
    send_fill(1'b0, 5);
    send_word(SHORT_SFD);
    chk("R3 short pattern accepted", hdr_rdy, 1);
    send_hdr(8'h0A, 8'h00, 16'h00C8, 1'b0, 1'b0);
    chk("R10 mode 1M", demod_mode, 0);
    chk("R6 short length", hdr_len, 16'h00C8);
    short_mode = 1'b0;
  endtask

  task automatic t_no_lock();
    restart(); tmo_sel = 2'd0;
    send_fill(1'b1, 4);
    send_word(LONG_SFD);
    chk("R4 no lock no rdy", hdr_rdy, 0);
    send_lock();
    send_fill(1'b1, 8);
    chk("R4 pre-lock bits ignored", hdr_rdy, 0);
  endtask

  task automatic t_timeout(input logic [1:0] sel, input int lim);
    restart(); tmo_sel = sel;
    send_lock();
    send_fill(1'b1, lim - 1);
    chk("R5 window open", reacq, 0);
    send_bit(1'b1, 1'b0);
    chk("R5 expiry reacq", reacq, 1);
    chk("R11 rdy low on reacq", hdr_rdy, 0);
    @(negedge clk);
    chk("R11 reacq one cycle", reacq, 0);
    send_word(LONG_SFD);
    chk("R4 after timeout no rdy", hdr_rdy, 0);
  endtask

  task automatic t_no_timeout();
    restart(); tmo_sel = 2'd0;
    send_lock();
    send_fill(1'b1, 300);
    chk("R5 disabled no reacq", reacq, 0);
    send_word(LONG_SFD);
    chk("R5 disabled late delimiter", hdr_rdy, 1);
  endtask

  task automatic t_crc_err();
    restart(); tmo_sel = 2'd0;
    send_lock(); send_fill(1'b1, 8); send_word(LONG_SFD);
    send_hdr(8'h6E, 8'h00, 16'd100, 1'b1, 1'b0);
    chk("R7 crc_err set", crc_err, 1);
    chk("R7 rdy fell", hdr_rdy, 0);
    chk("R7 reacq", reacq, 1);
    chk("R7 mode_vld low", mode_vld, 0);
    restart();
    chk("R8 survives rx_en drop", crc_err, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R8 cleared by read", crc_err, 0);
    send_lock(); send_fill(1'b1, 8); send_word(LONG_SFD);
    send_hdr(8'h14, 8'h00, 16'd5, 1'b1, 1'b1);
    chk("R8 set wins over read", crc_err, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_bad_sig();
    restart(); tmo_sel = 2'd0;
    send_lock(); send_fill(1'b1, 8); send_word(LONG_SFD);
    send_hdr(8'h55, 8'h00, 16'd10, 1'b0, 1'b0);
    chk("R10 unknown rate drops rdy", hdr_rdy, 0);
    chk("R10 unknown rate reacq", reacq, 1);
    chk("R10 unknown rate no crc_err", crc_err, 0);
  endtask

  task automatic t_modes();
    restart(); tmo_sel = 2'd3;
    send_lock(); send_fill(1'b1, 8); send_word(LONG_SFD);
    send_hdr(8'h14, 8'h00, 16'd7, 1'b0, 1'b0);
    chk("R10 mode 2M", demod_mode, 1);
    restart();
    send_lock(); send_fill(1'b1, 8); send_word(LONG_SFD);
    send_hdr(8'h37, 8'h00, 16'd7, 1'b0, 1'b0);
    chk("R10 mode 5.5M", demod_mode, 2);
    chk("R10 mode_vld", mode_vld, 1);
  endtask

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; short_mode = 1'b0; tmo_sel = 2'd0;
    lock_pulse = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    t_long_pkt();
    t_short_pkt();
    t_no_lock();
    t_timeout(2'd1, 64);
    t_timeout(2'd2, 128);
    t_timeout(2'd3, 256);
    t_no_timeout();
    t_crc_err();
    t_bad_sig();
    t_modes();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R1 watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule